// File: doc/BRIEF.md
# Serial-to-Register Access Target

This block lets an external host read and write an 8-bit-wide register space over a serial link with a chip select, a serial clock and one or two data lines. The host lowers chip select and sends a header made of a register address and a direction bit. It then streams data bytes. Each byte goes to, or comes from, the next address in sequence, and the stream ends when chip select rises. On the chip side the block drives a simple synchronous register port: one-cycle read and write strobes, an address, write data, and read data that returns one clock after a read strobe.

The serial pins are oversampled by the block's system clock. Each serial clock half-period must last at least 4 system clocks. Three configuration inputs are captured while chip select is high and stay fixed for the whole transaction:
- bit order: most-significant first or least-significant first;
- address length: 15 bits or a short 7-bit form;
- wire mode: separate in/out data lines, or one shared bidirectional line.

For the shared line, the pad is split into an input, an output and an output enable. The serial format is clock mode 0: the block captures input on the rising SCLK edge and changes its output on the falling edge.

Top module: `spi_regtgt`

## Requirements
- R1: With `cfg_lsb_first`=0 and `cfg_short_addr`=0, the header is 16 clocks. The first 15 clocks carry address bits 14 down to 0, the 16th carries the direction bit, and data bits travel bit 7 first.
- R2: With `cfg_lsb_first`=1 and `cfg_short_addr`=0, the 15 address bits travel bit 0 up to bit 14, followed by the direction bit, and data bits travel bit 0 first.
- R3: With `cfg_short_addr`=1, the header is 8 clocks: address bits 6..0 in the selected order, then the direction bit. Address bits 14..7 of the access are zero.
- R4: A direction bit of 0 means write. After the 8th data bit of each byte, `reg_wr_en` pulses high for one cycle with `reg_addr` and the assembled `reg_wdata`.
- R5: Byte k of a transaction uses header address plus k, modulo 2^15.
- R6: A direction bit of 1 means read. A read strobe goes out for the header address when the header ends, and for the next address after every 8 data clocks. Read bytes are shifted out one bit per falling SCLK edge in the configured bit order.
- R7: In 4-wire mode, `spi_sdo_oe` is 1 only during the data phase of a read. During a read the data input causes no write, and `spi_sdio_oe` stays 0.
- R8: In 3-wire mode, input is taken from `spi_sdio_i`. The target drives `spi_sdio_o` with `spi_sdio_oe`=1 only during the data phase of a read, and `spi_sdo_oe` stays 0. The two enables are never high together.
- R9: Raising `spi_cs_n` ends the transaction. Both output enables drop within 6 clocks, a partly received byte is not written, and the next transaction starts with a fresh header.
- R10: After reset, both strobes and both output enables are 0.
- R11: `reg_rd_en` and `reg_wr_en` are never high in the same cycle, and neither strobe is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lsb_first | input | 1 | 1: least-significant bit first |
| cfg_short_addr | input | 1 | 1: 7-bit address header |
| cfg_three_wire | input | 1 | 1: single bidirectional data line |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Host-to-target data, 4-wire mode |
| spi_sdo | output | 1 | Target-to-host data, 4-wire mode |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo |
| spi_sdio_i | input | 1 | Shared data line input, 3-wire mode |
| spi_sdio_o | output | 1 | Shared data line output value |
| spi_sdio_oe | output | 1 | Output enable for shared data line |
| reg_rd_en | output | 1 | Register read strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_addr | output | 15 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid one cycle after reg_rd_en |

## Verification
The bench runs all eight combinations of bit order, address length and wire mode, with random addresses, random byte counts and random write data. It compares writes and read bytes against a computed memory image. This separates a header-ordering fault from a data-ordering fault, because the two show up as wrong addresses and wrong values respectively.

Directed cases cover the following, each aimed at the increment and abort paths:
- a write that crosses the top of the 15-bit address space;
- a short-address write whose high header bits were set by the caller;
- a write cut off mid-byte;
- a header cut off mid-way.

During reads the unused input is fed random bits, so any write caused by that input is exposed.

// File: rtl/spi_regtgt_pkg.sv
package spi_regtgt_pkg;

  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_DATA = 1'b1
  } phase_t;

  // Bit position of an address bit given its clock index within the header.
  function automatic int unsigned hdr_pos(input int unsigned cnt,
                                          input int unsigned abits,
                                          input logic lsb);
    return lsb ? cnt : (abits - 1 - cnt);
  endfunction

  // Bit position of a data bit given its clock index within the byte.
  function automatic int unsigned data_pos(input int unsigned cnt,
                                           input int unsigned dw,
                                           input logic lsb);
    return lsb ? cnt : (dw - 1 - cnt);
  endfunction

endpackage

// File: rtl/spi_regtgt_sync.sv
module spi_regtgt_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES+1];

  assign pipe[0] = d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s+1] <= INIT;
      else        pipe[s+1] <= pipe[s];
    end
  end

  assign q = pipe[STAGES];
endmodule

// File: rtl/spi_regtgt_ctrl.sv
module spi_regtgt_ctrl
  import spi_regtgt_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int SHORT_W = 7,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              din4_s,
  input  logic              din3_s,
  input  logic              cfg_lsb_first,
  input  logic              cfg_short_addr,
  input  logic              cfg_three_wire,
  output logic              reg_rd_en,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              tx_bit,
  output logic              tx_en,
  output logic              three_wire
);
  localparam int CNT_W = $clog2(ADDR_W + 2);
  localparam int AP_W  = $clog2(ADDR_W);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] ABITS_L = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] ABITS_S = CNT_W'(SHORT_W);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  // Edge detection on the synchronized serial clock
  logic sclk_d;
  logic cs_act, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign cs_act = ~cs_n_s;
  assign rise   = cs_act & sclk_s & ~sclk_d;
  assign fall   = cs_act & ~sclk_s & sclk_d;

  // Configuration is captured while chip select is inactive
  logic lsb_q, short_q, m3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q   <= 1'b0;
      short_q <= 1'b0;
      m3_q    <= 1'b0;
    end else if (!cs_act) begin
      lsb_q   <= cfg_lsb_first;
      short_q <= cfg_short_addr;
      m3_q    <= cfg_three_wire;
    end
  end

  assign three_wire = m3_q;

  // Transaction state
  phase_t            phase;
  logic [CNT_W-1:0]  hdr_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr_acc, ptr;
  logic [DATA_W-1:0] rx_byte, tx_buf, wr_byte;
  logic              rw_q, rd_pend;

  // Named internal events
  logic              din, hdr_bit, hdr_last, data_bit, byte_last;
  logic [CNT_W-1:0]  abits;
  logic [AP_W-1:0]   apos;
  logic [BIT_W-1:0]  dpos;

  assign din       = m3_q ? din3_s : din4_s;
  assign abits     = short_q ? ABITS_S : ABITS_L;
  assign hdr_bit   = rise && (phase == PH_HDR);
  assign hdr_last  = hdr_bit && (hdr_cnt == abits);
  assign data_bit  = rise && (phase == PH_DATA);
  assign byte_last = data_bit && (bit_cnt == BIT_LAST);

  always_comb begin
    apos = AP_W'(hdr_pos(32'(hdr_cnt), 32'(abits), lsb_q));
    dpos = BIT_W'(data_pos(32'(bit_cnt), DATA_W, lsb_q));
    wr_byte = rx_byte;
    wr_byte[dpos] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_HDR;
      hdr_cnt   <= '0;
      bit_cnt   <= '0;
      addr_acc  <= '0;
      ptr       <= '0;
      rx_byte   <= '0;
      tx_buf    <= '0;
      rw_q      <= 1'b0;
      rd_pend   <= 1'b0;
      reg_rd_en <= 1'b0;
      reg_wr_en <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      tx_bit    <= 1'b0;
      tx_en     <= 1'b0;
    end else begin
      reg_rd_en <= 1'b0;
      reg_wr_en <= 1'b0;
      rd_pend   <= reg_rd_en;
      if (rd_pend) tx_buf <= reg_rdata;

      if (!cs_act) begin
        phase    <= PH_HDR;
        hdr_cnt  <= '0;
        bit_cnt  <= '0;
        addr_acc <= '0;
        rx_byte  <= '0;
        rw_q     <= 1'b0;
        tx_en    <= 1'b0;
      end else begin
        if (hdr_bit) begin
          hdr_cnt <= hdr_cnt + 1'b1;
          if (!hdr_last) begin
            addr_acc[apos] <= din;
          end else begin
            phase <= PH_DATA;
            rw_q  <= din;
            if (din) begin
              reg_rd_en <= 1'b1;
              reg_addr  <= addr_acc;
              ptr       <= addr_acc + ADDR_ONE;
            end else begin
              ptr       <= addr_acc;
            end
          end
        end

        if (data_bit) begin
          bit_cnt <= bit_cnt + 1'b1;
          if (!rw_q) rx_byte[dpos] <= din;
          if (byte_last) begin
            bit_cnt  <= '0;
            rx_byte  <= '0;
            reg_addr <= ptr;
            ptr      <= ptr + ADDR_ONE;
            if (rw_q) begin
              reg_rd_en <= 1'b1;
            end else begin
              reg_wr_en <= 1'b1;
              reg_wdata <= wr_byte;
            end
          end
        end

        if (fall && (phase == PH_DATA) && rw_q) begin
          tx_bit <= tx_buf[dpos];
          tx_en  <= 1'b1;
        end
      end
    end
  end

  // Assertions
  p_no_strobe_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_en && reg_wr_en));

  p_wr_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  p_rd_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || reg_rd_en) |-> (ptr == reg_addr + ADDR_ONE));

  p_drive_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (rw_q && (phase == PH_DATA)));

  p_release_on_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !tx_en);

  p_tx_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> (tx_buf == $past(reg_rdata)));

  p_short_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && short_q && $past(phase == PH_HDR)) |->
      (reg_addr[ADDR_W-1:SHORT_W] == '0));
endmodule

// File: rtl/spi_regtgt_pinmux.sv
module spi_regtgt_pinmux (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_bit,
  input  logic tx_en,
  input  logic three_wire,
  output logic sdo,
  output logic sdo_oe,
  output logic sdio_o,
  output logic sdio_oe
);
  assign sdo     = tx_bit;
  assign sdio_o  = tx_bit;
  assign sdo_oe  = tx_en & ~three_wire;
  assign sdio_oe = tx_en & three_wire;

  p_pins_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe && sdio_oe));

  p_no_drive_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!sdo_oe && !sdio_oe));
endmodule

// File: rtl/spi_regtgt.sv
module spi_regtgt #(
  parameter int ADDR_W      = 15,
  parameter int SHORT_W     = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lsb_first,
  input  logic              cfg_short_addr,
  input  logic              cfg_three_wire,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic              spi_sdio_i,
  output logic              spi_sdio_o,
  output logic              spi_sdio_oe,
  output logic              reg_rd_en,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int PIN_N = 4;
  localparam logic [PIN_N-1:0] PIN_INIT = 4'b0010; // chip select idles high

  logic [PIN_N-1:0] pins_s;
  logic tx_bit, tx_en, three_wire;

  spi_regtgt_sync #(
    .W      (PIN_N),
    .STAGES (SYNC_STAGES),
    .INIT   (PIN_INIT)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sdio_i, spi_sdi, spi_cs_n, spi_sclk}),
    .q     (pins_s)
  );

  spi_regtgt_ctrl #(
    .ADDR_W  (ADDR_W),
    .SHORT_W (SHORT_W),
    .DATA_W  (DATA_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .sclk_s         (pins_s[0]),
    .cs_n_s         (pins_s[1]),
    .din4_s         (pins_s[2]),
    .din3_s         (pins_s[3]),
    .cfg_lsb_first  (cfg_lsb_first),
    .cfg_short_addr (cfg_short_addr),
    .cfg_three_wire (cfg_three_wire),
    .reg_rd_en      (reg_rd_en),
    .reg_wr_en      (reg_wr_en),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .tx_bit         (tx_bit),
    .tx_en          (tx_en),
    .three_wire     (three_wire)
  );

  spi_regtgt_pinmux u_pinmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_bit     (tx_bit),
    .tx_en      (tx_en),
    .three_wire (three_wire),
    .sdo        (spi_sdo),
    .sdo_oe     (spi_sdo_oe),
    .sdio_o     (spi_sdio_o),
    .sdio_oe    (spi_sdio_oe)
  );
endmodule

// File: tb/spi_regtgt_bench.sv
`timescale 1ns/1ps
module spi_regtgt_bench;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_lsb_first = 1'b0, cfg_short_addr = 1'b0, cfg_three_wire = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_sdi = 1'b0, spi_sdio_i = 1'b0;
  logic spi_sdo, spi_sdo_oe, spi_sdio_o, spi_sdio_oe;
  logic reg_rd_en, reg_wr_en;
  logic [14:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata = 8'h00;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int wlog_n = 0, overlap_n = 0;
  logic [14:0] wlog_a [32];
  logic [7:0]  wlog_d [32];
  logic [7:0]  wbuf [16];

  always #2 clk = ~clk;

  spi_regtgt u_spi_regtgt (
    .clk(clk), .rst_n(rst_n),
    .cfg_lsb_first(cfg_lsb_first), .cfg_short_addr(cfg_short_addr),
    .cfg_three_wire(cfg_three_wire),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .spi_sdio_i(spi_sdio_i), .spi_sdio_o(spi_sdio_o), .spi_sdio_oe(spi_sdio_oe),
    .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] mem_model(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ 8'hA5;
  endfunction

  // Register space model: one cycle read latency
  always @(posedge clk) if (reg_rd_en) reg_rdata <= mem_model(reg_addr);

  always @(negedge clk) begin
    if (reg_wr_en && wlog_n < 32) begin
      wlog_a[wlog_n] = reg_addr;
      wlog_d[wlog_n] = reg_wdata;
      wlog_n++;
    end
    if (reg_rd_en && reg_wr_en) overlap_n++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One serial clock: present a bit, sample target output, rising then falling edge
  bit oe_bad;
  task automatic sclk_bit(input bit din, input bit expect_drive, output bit dout);
    if (cfg_three_wire) begin
      spi_sdio_i = din; spi_sdi = 1'($urandom);
    end else begin
      spi_sdi = din; spi_sdio_i = 1'($urandom);
    end
    wait_clk(HP);
    dout = cfg_three_wire ? spi_sdio_o : spi_sdo;
    if (cfg_three_wire) begin
      if (spi_sdio_oe !== expect_drive || spi_sdo_oe !== 1'b0) oe_bad = 1'b1;
    end else begin
      if (spi_sdo_oe !== expect_drive || spi_sdio_oe !== 1'b0) oe_bad = 1'b1;
    end
    spi_sclk = 1'b1;
    wait_clk(HP);
    spi_sclk = 1'b0;
  endtask

  task automatic run_txn(input bit lsb, input bit sh, input bit w3, input bit rw,
                         input logic [14:0] addr, input int nbytes,
                         input int extra_bits, input string tag);
    int alen;
    logic [14:0] eff;
    bit b, dout;
    logic [7:0] got;
    string mreq;
    mreq = w3 ? "R8" : "R7";
    cfg_lsb_first = lsb; cfg_short_addr = sh; cfg_three_wire = w3;
    for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom);
    wait_clk(3);
    wlog_n = 0; oe_bad = 1'b0;
    alen = sh ? 7 : 15;
    eff = sh ? {8'h00, addr[6:0]} : addr;
    spi_cs_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i <= alen; i++) begin
      if (i < alen) b = addr[lsb ? i : alen - 1 - i];
      else          b = rw;
      sclk_bit(b, 1'b0, dout);
    end
    for (int k = 0; k < nbytes; k++) begin
      got = 8'h00;
      for (int j = 0; j < 8; j++) begin
        int p;
        p = lsb ? j : 7 - j;
        sclk_bit(rw ? 1'($urandom) : wbuf[k][p], rw, dout);
        got[p] = dout;
      end
      if (rw) check(got == mem_model(15'(eff + 15'(k))), tag, "R6 read byte",
                    32'(got), 32'(mem_model(15'(eff + 15'(k)))));
    end
    for (int j = 0; j < extra_bits; j++) sclk_bit(1'($urandom), rw, dout);
    wait_clk(HP);
    spi_cs_n = 1'b1;
    wait_clk(6);
    check(!spi_sdo_oe && !spi_sdio_oe, "R9", "enables after cs release",
          {30'd0, spi_sdo_oe, spi_sdio_oe}, 32'd0);
    check(!oe_bad, mreq, "output enable pattern", 32'(oe_bad), 32'd0);
    wait_clk(4 * HP);
    if (rw) begin
      check(wlog_n == 0, "R7", "no write during read", 32'(wlog_n), 32'd0);
    end else begin
      check(wlog_n == nbytes, "R4", "write count (R9 partial dropped)",
            32'(wlog_n), 32'(nbytes));
      for (int k = 0; k < nbytes && k < wlog_n; k++) begin
        check(wlog_a[k] == 15'(eff + 15'(k)), tag, "R5 write address",
              32'(wlog_a[k]), 32'(15'(eff + 15'(k))));
        check(wlog_d[k] == wbuf[k], tag, "R4 write data",
              32'(wlog_d[k]), 32'(wbuf[k]));
      end
    end
  endtask

  task automatic abort_header(input int nbits);
    bit dout;
    cfg_three_wire = 1'b0; cfg_short_addr = 1'b0;
    wait_clk(3);
    wlog_n = 0;
    spi_cs_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < nbits; i++) sclk_bit(1'b1, 1'b0, dout);
    wait_clk(HP);
    spi_cs_n = 1'b1;
    wait_clk(4 * HP);
    check(wlog_n == 0, "R9", "no access from cut header", 32'(wlog_n), 32'd0);
  endtask

  string tg;

  initial begin
    void'($urandom(32'd7351));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    // R10: quiet after reset
    check(!reg_rd_en && !reg_wr_en, "R10", "strobes after reset",
          {30'd0, reg_rd_en, reg_wr_en}, 32'd0);
    check(!spi_sdo_oe && !spi_sdio_oe, "R10", "enables after reset",
          {30'd0, spi_sdo_oe, spi_sdio_oe}, 32'd0);

    // Directed cases
    run_txn(1'b0, 1'b0, 1'b0, 1'b0, 15'h1234, 2, 0, "R1");
    run_txn(1'b1, 1'b0, 1'b0, 1'b0, 15'h1234, 2, 0, "R2");
    run_txn(1'b0, 1'b0, 1'b0, 1'b0, 15'h7FFE, 3, 0, "R5");   // wraps to 0
    run_txn(1'b0, 1'b1, 1'b0, 1'b0, 15'h1F7F, 2, 0, "R3");   // 0x7F, 0x80
    run_txn(1'b1, 1'b1, 1'b1, 1'b0, 15'h0005, 2, 0, "R3");
    run_txn(1'b0, 1'b0, 1'b0, 1'b0, 15'h0400, 2, 5, "R9");   // partial byte
    abort_header(6);
    run_txn(1'b0, 1'b0, 1'b0, 1'b0, 15'h2222, 1, 0, "R9");   // fresh header
    run_txn(1'b0, 1'b0, 1'b0, 1'b1, 15'h0ABC, 3, 0, "R1");
    run_txn(1'b1, 1'b0, 1'b1, 1'b1, 15'h7FFF, 2, 0, "R2");   // read wrap, 3-wire
    run_txn(1'b0, 1'b1, 1'b1, 1'b1, 15'h0042, 2, 3, "R3");

    // Constrained random
    for (int t = 0; t < 30; t++) begin
      bit lsb, sh, w3, rw;
      lsb = 1'($urandom); sh = 1'($urandom);
      w3 = 1'($urandom); rw = 1'($urandom);
      tg = sh ? "R3" : (lsb ? "R2" : "R1");
      run_txn(lsb, sh, w3, rw, 15'($urandom), 1 + int'($urandom % 4), 0, tg);
    end

    check(overlap_n == 0, "R11", "read and write strobes together",
          32'(overlap_n), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule